// File: doc/BRIEF.md
# Event-Selectable Performance Counter Unit

This block is a small monitoring unit that tallies hardware events and clock cycles. It has two general counters and one cycle counter. Each general counter follows one line of an event pulse vector, chosen by an 8-bit code. The cycle counter counts every enabled clock, or with a prescaler one count per 64 enabled clocks. Software reaches a single control word and the three counters through a two-bit indexed register port. Register reads are combinational. Writes take effect at the next rising clock edge.

No counter has a run bit of its own. One global enable gates all three counters. To stop a general counter, software gives it a code that has no source behind it, such as 0x20. When a counter wraps, it sets a sticky overflow flag. One interrupt line merges the flags that are enabled. The handler reads the control word to see which counter wrapped. It then writes the same value back, which acknowledges every flag it saw.

Top module: `perf_counter_unit`

## Requirements
- R1: After a synchronous reset, the control word and all three counters read 0 and `irq` is low.
- R2: `reg_sel` selects the target: 0 is the control word, 1 the cycle counter, 2 general counter 0, 3 general counter 1. Any 32-bit value, zero included, written to a counter reads back exactly. A counter write takes priority over an increment at the same edge.
- R3: While enabled, a general counter adds 1 on each clock where its selected source is high. Codes 0 to 31 select `evt_in[code]`. Code 0xFF counts every enabled clock.
- R4: While control bit 0 (global enable) is 0, no counter changes except through a port write or a reset strobe.
- R5: A general counter whose code is 0x20, or any other code from 32 to 0xFE, never increments.
- R6: Writing control bit 1 as 1 clears both general counters. Writing control bit 2 as 1 clears the cycle counter. Both bits always read back as 0.
- R7: With control bit 3 clear, the cycle counter adds 1 per enabled clock. With bit 3 set, it adds 1 once every 64 enabled clocks. The prescaler restarts whenever bit 3 is clear or the cycle counter is cleared.
- R8: A wrap from 0xFFFFFFFF to 0 sets a sticky flag: bit 8 for counter 0, bit 9 for counter 1, bit 10 for the cycle counter.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it alone. If a wrap and a clear occur at the same edge, the flag ends up set. Writing back a value just read acknowledges all flags in it.
- R10: `irq` is high exactly when some flag is set and its enable is set. The enables are bit 4 for counter 0, bit 5 for counter 1 and bit 6 for the cycle counter.
- R11: Counter 0's code is in control bits 27:20 and counter 1's code is in bits 19:12. Bits 7, 11 and 31:28 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register index for read and write |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| evt_in | input | 32 | Per-cycle event pulses, one per source code |
| irq | output | 1 | Combined overflow interrupt |

## Verification
A wrong count or a mis-decoded code appears as a counter value that drifts from the reference model. The drift shows at the first read of that counter after the bad increment. A flag or enable stored in the wrong place changes `irq`, which is compared at every clock, so the error is seen one cycle after the bad edge. Prescaler phase errors show after at most 64 enabled clocks as a cycle counter value that is off by one.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int REG_W   = 32;
    localparam int CODE_W  = 8;
    localparam int N_CNT   = 3;   // index 0: general 0, 1: general 1, 2: cycles

    // control word bit positions (software decodes these)
    localparam int B_EN      = 0;
    localparam int B_CLR_EVT = 1;
    localparam int B_CLR_CYC = 2;
    localparam int B_DIV     = 3;
    localparam int B_IEN     = 4;   // three bits
    localparam int B_OVF     = 8;   // three bits
    localparam int B_CODE1   = 12;
    localparam int B_CODE0   = 20;

    localparam logic [CODE_W-1:0] CODE_CYCLES = 8'hFF;
    localparam logic [CODE_W-1:0] CODE_DEAD   = 8'h20;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_CYC  = 2'd1,
        SEL_GEN0 = 2'd2,
        SEL_GEN1 = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [CODE_W-1:0] code0;
        logic [CODE_W-1:0] code1;
        logic [N_CNT-1:0]  ovf;
        logic [N_CNT-1:0]  ien;
        logic              div;
        logic              en;
    } ctrl_t;

    function automatic logic [REG_W-1:0] ctrl_word(ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[B_EN]                    = c.en;
        w[B_DIV]                   = c.div;
        w[B_IEN +: N_CNT]          = c.ien;
        w[B_OVF +: N_CNT]          = c.ovf;
        w[B_CODE0 +: CODE_W]       = c.code0;
        w[B_CODE1 +: CODE_W]       = c.code1;
        return w;
    endfunction

endpackage

// File: rtl/pcu_event_sel.sv
module pcu_event_sel
    import pcu_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [CODE_W-1:0]  code,
    input  logic [NUM_SRC-1:0] evt_vec,
    output logic               hit
);
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (code == CODE_W'(i)) hit = evt_vec[i];
        end
        if (code == CODE_CYCLES) hit = 1'b1;
    end
endmodule

// File: rtl/pcu_counter.sv
module pcu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic         wrap
);
    assign wrap = inc && !load && !clr && (&value);

    always_ff @(posedge clk) begin
        if (rst)       value <= '0;
        else if (load) value <= load_val;
        else if (clr)  value <= '0;
        else if (inc)  value <= value + 1'b1;
    end

    // R2: a port write lands exactly
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> value == $past(load_val));

    // R3: one step per increment, wrapping past all ones
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && !clr) |=> value == W'($past(value) + 1'b1));

    // R4: no cause, no change
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!inc && !load && !clr) |=> $stable(value));
endmodule

// File: rtl/pcu_prescale.sv
module pcu_prescale #(
    parameter int PRE_W = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic tick
);
    logic [PRE_W-1:0] cnt;

    assign tick = adv && (&cnt);

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (adv)   cnt <= cnt + 1'b1;
    end

    // R7: the phase restarts after each divided tick
    p_tick_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr) |=> cnt == '0);
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
    import pcu_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_SRC = 32,
    parameter int PRE_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         reg_sel,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic               irq
);
    localparam int N_GEN = 2;

    ctrl_t              ctrl_q;
    reg_sel_e           sel;
    logic               wr_ctrl;
    logic               clr_evt_stb;
    logic               clr_cyc_stb;
    logic [N_CNT-1:0]   inc;
    logic [N_CNT-1:0]   load;
    logic [N_CNT-1:0]   clr;
    logic [N_CNT-1:0]   wrap;
    logic [N_CNT-1:0]   ovf_clr;
    logic [N_CNT-1:0]   ovf_next;
    logic [CNT_W-1:0]   cnt_val [N_CNT];
    logic [CODE_W-1:0]  code_sel [N_GEN];
    logic               pre_tick;

    assign sel         = reg_sel_e'(reg_sel);
    assign wr_ctrl     = reg_wr && (sel == SEL_CTRL);
    assign clr_evt_stb = wr_ctrl && reg_wdata[B_CLR_EVT];
    assign clr_cyc_stb = wr_ctrl && reg_wdata[B_CLR_CYC];

    assign code_sel[0] = ctrl_q.code0;
    assign code_sel[1] = ctrl_q.code1;

    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        logic hit;

        pcu_event_sel #(.NUM_SRC(NUM_SRC)) u_sel (
            .code    (code_sel[g]),
            .evt_vec (evt_in),
            .hit     (hit)
        );

        assign inc[g]  = ctrl_q.en && hit;
        assign load[g] = reg_wr && (sel == reg_sel_e'(SEL_GEN0 + g));
        assign clr[g]  = clr_evt_stb;
    end

    pcu_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (!ctrl_q.div || clr_cyc_stb),
        .adv  (ctrl_q.en && ctrl_q.div),
        .tick (pre_tick)
    );

    assign inc[2]  = ctrl_q.en && (ctrl_q.div ? pre_tick : 1'b1);
    assign load[2] = reg_wr && (sel == SEL_CYC);
    assign clr[2]  = clr_cyc_stb;

    for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
        pcu_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .inc      (inc[k]),
            .clr      (clr[k]),
            .load     (load[k]),
            .load_val (reg_wdata[CNT_W-1:0]),
            .value    (cnt_val[k]),
            .wrap     (wrap[k])
        );
    end

    // sticky flags: a wrap at the clearing edge wins
    assign ovf_clr  = wr_ctrl ? reg_wdata[B_OVF +: N_CNT] : '0;
    assign ovf_next = wrap | (ctrl_q.ovf & ~ovf_clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q.ovf <= ovf_next;
            if (wr_ctrl) begin
                ctrl_q.en    <= reg_wdata[B_EN];
                ctrl_q.div   <= reg_wdata[B_DIV];
                ctrl_q.ien   <= reg_wdata[B_IEN +: N_CNT];
                ctrl_q.code0 <= reg_wdata[B_CODE0 +: CODE_W];
                ctrl_q.code1 <= reg_wdata[B_CODE1 +: CODE_W];
            end
        end
    end

    assign irq = |(ctrl_q.ovf & ctrl_q.ien);

    always_comb begin
        unique case (sel)
            SEL_CTRL: reg_rdata = ctrl_word(ctrl_q);
            SEL_CYC:  reg_rdata = REG_W'(cnt_val[2]);
            SEL_GEN0: reg_rdata = REG_W'(cnt_val[0]);
            default:  reg_rdata = REG_W'(cnt_val[1]);
        endcase
    end

    // R8: every wrap leaves its flag set
    p_wrap_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (|wrap) |=> ((ctrl_q.ovf & $past(wrap)) == $past(wrap)));

    // R9: flags only drop through a control write
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> ((ctrl_q.ovf & $past(ctrl_q.ovf)) == $past(ctrl_q.ovf)));

    // R10: no enables, no interrupt
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.ien == '0) |-> !irq);

    // R5: a dead code freezes counter 0
    p_dead_code_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.code0 == CODE_DEAD && !load[0] && !clr_evt_stb) |=> $stable(cnt_val[0]));

    // R4: disabled unit holds every counter
    p_gated_r4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !reg_wr) |=> ($stable(cnt_val[0]) && $stable(cnt_val[1]) && $stable(cnt_val[2])));

    // R6: strobes never read back
    p_strobe_rd_r6: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_CTRL) |-> (reg_rdata[B_CLR_CYC:B_CLR_EVT] == 2'b00));
endmodule

// File: tb/perf_counter_unit_tb.sv
module perf_counter_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_in = '0;
    logic        irq;

    int n_total = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;   // 250 MHz

    perf_counter_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_in    (evt_in),
        .irq       (irq)
    );

    // ---------------- behavioural reference ----------------
    bit [31:0] m_cnt [3];    // 0: general 0, 1: general 1, 2: cycles
    bit        m_en, m_div;
    bit [2:0]  m_ien, m_ovf;
    bit [7:0]  m_code [2];
    int        m_pre;

    function automatic bit src_hit(bit [7:0] c);
        if (c == 8'hFF) return 1'b1;
        if (c < 32) return evt_in[c];
        return 1'b0;
    endfunction

    function automatic bit [31:0] model_read(int s);
        bit [31:0] w;
        case (s)
            0: begin
                w = '0;
                w[0] = m_en; w[3] = m_div; w[6:4] = m_ien; w[10:8] = m_ovf;
                w[27:20] = m_code[0]; w[19:12] = m_code[1];
            end
            1: w = m_cnt[2];
            2: w = m_cnt[0];
            default: w = m_cnt[1];
        endcase
        return w;
    endfunction

    always @(posedge clk) begin : model
        bit [2:0] inc, wrp;
        bit wc, ld, cl;
        int s;
        if (rst) begin
            m_cnt[0] = 0; m_cnt[1] = 0; m_cnt[2] = 0;
            m_en = 0; m_div = 0; m_ien = 0; m_ovf = 0;
            m_code[0] = 0; m_code[1] = 0; m_pre = 0;
        end else begin
            wc = reg_wr && reg_sel == 2'd0;
            inc[0] = m_en && src_hit(m_code[0]);
            inc[1] = m_en && src_hit(m_code[1]);
            inc[2] = m_en && (m_div ? (m_pre == 63) : 1'b1);
            if (!m_div || (wc && reg_wdata[2])) m_pre = 0;
            else if (m_en) m_pre = (m_pre + 1) % 64;
            for (int k = 0; k < 3; k++) begin
                s  = (k == 2) ? 1 : k + 2;
                ld = reg_wr && reg_sel == 2'(s);
                cl = wc && reg_wdata[(k == 2) ? 2 : 1];
                wrp[k] = 0;
                if (ld) m_cnt[k] = reg_wdata;
                else if (cl) m_cnt[k] = 0;
                else if (inc[k]) begin
                    if (m_cnt[k] == 32'hFFFF_FFFF) wrp[k] = 1;
                    m_cnt[k] = m_cnt[k] + 1;
                end
            end
            for (int k = 0; k < 3; k++)
                m_ovf[k] = wrp[k] | (m_ovf[k] & !(wc && reg_wdata[8+k]));
            if (wc) begin
                m_en = reg_wdata[0]; m_div = reg_wdata[3]; m_ien = reg_wdata[6:4];
                m_code[0] = reg_wdata[27:20]; m_code[1] = reg_wdata[19:12];
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(string req, bit [31:0] act, bit [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R10: interrupt compared every clock
    always @(negedge clk) begin
        if (!rst) check("R10 irq", {31'd0, irq}, {31'd0, |(m_ovf & m_ien)});
    end

    task automatic wr(int s, bit [31:0] d);
        @(negedge clk);
        reg_sel = 2'(s); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int s, string req);
        @(negedge clk);
        reg_sel = 2'(s);
        #1;
        check(req, reg_rdata, model_read(s));
    endtask

    task automatic run(int n, int mode);
        repeat (n) begin
            @(negedge clk);
            case (mode)
                0: evt_in = '0;
                1: evt_in = '1;
                default: evt_in = $urandom;
            endcase
        end
    endtask

    function automatic bit [31:0] ctl(bit en, bit div, bit [2:0] ien, bit [7:0] c0, bit [7:0] c1);
        return {4'd0, c0, c1, 1'b0, 3'd0, 1'b0, ien, div, 2'b00, en};
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        bit [31:0] v, hold;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            rd(s, "R1 reset value");
            check("R1 reset absolute", reg_rdata, 32'd0);
        end

        // R2 indexed access, any value including zero
        wr(2, 32'hA5A5_1234); wr(3, 32'h0F0F_F0F0); wr(1, 32'hDEAD_BEEF);
        rd(2, "R2 gen0 write"); check("R2 gen0 absolute", reg_rdata, 32'hA5A5_1234);
        rd(3, "R2 gen1 write"); rd(1, "R2 cyc write");
        wr(2, 32'd0); rd(2, "R2 zero write"); check("R2 zero absolute", reg_rdata, 32'd0);

        // R3 event selection: branch code on 0, every-cycle code on 1
        wr(0, ctl(1, 0, 3'b000, 8'h05, 8'hFF));
        run(50, 2);
        rd(2, "R3 gen0 event 0x05"); rd(3, "R3 gen1 cycles code"); rd(1, "R7 cyc undivided");
        wr(0, ctl(1, 0, 3'b000, 8'h1F, 8'h0B));
        run(40, 2);
        rd(2, "R3 gen0 top source"); rd(3, "R3 gen1 event 0x0B");

        // R2 write wins over same-cycle increment (gen1 on cycles code)
        wr(0, ctl(1, 0, 3'b000, 8'h00, 8'hFF));
        wr(3, 32'h0000_0100); rd(3, "R2 write beats increment");

        // R4 global enable off
        wr(0, ctl(0, 0, 3'b000, 8'hFF, 8'hFF));
        rd(2, "R4 before"); hold = reg_rdata;
        run(30, 1);
        rd(2, "R4 gen0 frozen"); check("R4 gen0 absolute", reg_rdata, hold);
        rd(1, "R4 cyc frozen");

        // R5 dead code
        wr(0, ctl(1, 0, 3'b000, 8'h20, 8'h80));
        rd(2, "R5 before"); hold = reg_rdata;
        run(30, 1);
        rd(2, "R5 dead code"); check("R5 dead absolute", reg_rdata, hold);
        rd(3, "R5 unconnected code");

        // R6 strobes
        wr(0, ctl(1, 0, 3'b000, 8'h20, 8'h20) | 32'h2);
        rd(2, "R6 gen0 cleared"); rd(3, "R6 gen1 cleared"); rd(1, "R6 cyc untouched");
        wr(0, ctl(1, 0, 3'b000, 8'h20, 8'h20) | 32'h6);
        rd(1, "R6 cyc cleared");
        rd(0, "R6 ctrl read"); check("R6 strobe bits zero", reg_rdata & 32'h6, 32'd0);

        // R7 divided cycles
        wr(0, ctl(1, 1, 3'b000, 8'h20, 8'h20) | 32'h4);
        run(200, 0);
        rd(1, "R7 cyc divided");
        wr(0, ctl(0, 1, 3'b000, 8'h20, 8'h20));
        run(70, 0);
        rd(1, "R7 divided gated");
        wr(0, ctl(1, 1, 3'b000, 8'h20, 8'h20));
        run(131, 0);
        rd(1, "R7 divided resume");

        // R8/R10 overflow of general 0 with its enable
        wr(0, ctl(1, 0, 3'b001, 8'h03, 8'h20));
        wr(2, 32'hFFFF_FFFE);
        run(4, 1);
        rd(2, "R8 gen0 wrapped"); rd(0, "R8 gen0 flag");
        check("R8 bit8 set", reg_rdata & 32'h100, 32'h100);
        check("R10 irq on", {31'd0, irq}, 32'd1);

        // R8 cycle counter wrap with enable off: flag but no new irq source
        wr(1, 32'hFFFF_FFF0);
        run(20, 0);
        rd(0, "R8 cyc flag"); check("R8 bit10 set", reg_rdata & 32'h400, 32'h400);

        // R9 write-back acknowledges everything read
        evt_in = '0;
        rd(0, "R9 pre ack"); v = reg_rdata;
        wr(0, v);
        rd(0, "R9 after ack"); check("R9 flags clear", reg_rdata & 32'h700, 32'd0);

        // R9 writing zero leaves a flag; set beats clear
        wr(0, ctl(1, 0, 3'b110, 8'h20, 8'hFF));
        wr(3, 32'hFFFF_FFFE);
        wr(0, ctl(1, 0, 3'b110, 8'h20, 8'hFF) | 32'h200);
        rd(0, "R9 set beats clear"); check("R9 bit9 held", reg_rdata & 32'h200, 32'h200);
        wr(0, ctl(1, 0, 3'b110, 8'h20, 8'h20));
        rd(0, "R9 zero keeps flag"); check("R9 bit9 kept", reg_rdata & 32'h200, 32'h200);
        check("R10 irq via gen1", {31'd0, irq}, 32'd1);
        wr(0, ctl(1, 0, 3'b000, 8'h20, 8'h20));
        rd(0, "R10 masked");
        check("R10 irq masked", {31'd0, irq}, 32'd0);

        // R11 field placement and unused bits
        wr(0, 32'hFFFF_FFF9);
        rd(0, "R11 all ones");
        check("R11 unused zero", reg_rdata & ~32'h0FFF_F779, 32'd0);
        wr(0, ctl(0, 0, 3'b000, 8'hC3, 8'h5A));
        rd(0, "R11 code fields");
        check("R11 code0 field", (reg_rdata >> 20) & 32'hFF, 32'hC3);
        check("R11 code1 field", (reg_rdata >> 12) & 32'hFF, 32'h5A);

        // R1 reset again from a busy state
        wr(0, ctl(1, 0, 3'b111, 8'hFF, 8'hFF));
        run(10, 2);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int s = 0; s < 4; s++) rd(s, "R1 re-reset");

        run(5, 0);
        finish_run();
    end

endmodule